// File: doc/BRIEF.md
# Mono-Mode Subframe Pairing Packer

This block takes words from a stereo serial-audio input stage and turns them into two-subframe frames for a downstream IEC 60958-style frame builder. The builder does the biphase coding, preambles and parity. In stereo operation, each input strobe carries a left and a right word, and it becomes exactly one frame: left goes in subframe A and right goes in subframe B.

In mono operation, only one input channel is kept. Two successive samples of that channel are packed into one frame, with the earlier sample in A and the later one in B. Frames therefore leave at half the input word rate, and the samples of the other channel are dropped.

Each frame carries a one-bit tag. The tag tells the builder which channel-status block to transmit with that frame. Any change to the mode bit or to the channel choice restarts the pairing. This way no frame ever combines samples taken under two different configurations.

Top module: `subframe_pair_packer`

## Requirements
- R1: A synchronous active-high reset `rst` drives `out_valid` low in the cycle after it is sampled and empties the pair phase. The first mono strobe after reset is therefore always an A sample.
- R2: With `mono_en`=0, each `in_valid` strobe produces `out_valid` high in the next cycle, with `out_a`=`in_left` and `out_b`=`in_right` of that strobe.
- R3: With `mono_en`=1, `chan_sel` chooses the kept channel (0 = `in_left`, 1 = `in_right`). The first strobe of a pair is held. The second strobe produces `out_valid` in the next cycle, with `out_a` = the held (earlier) sample and `out_b` = the later sample.
- R4: In mono operation, the words on the channel that is not selected never appear on `out_a` or `out_b`.
- R5: In mono operation, exactly one frame is emitted per two strobes. A strobe that opens a pair produces no `out_valid`.
- R6: `out_tag` equals the `cs_sel` value present at the strobe that completes the frame, in both modes.
- R7: If `mono_en` or `chan_sel` differs from its value in the previous cycle, the pair phase is cleared. A strobe in that same cycle becomes the A sample of a new pair.
- R8: `out_valid` is a one-cycle pulse per completed frame and is never raised without a completing strobe in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe: a stereo word pair is present |
| in_left | input | 24 | Left-channel sample word |
| in_right | input | 24 | Right-channel sample word |
| mono_en | input | 1 | 1 = mono pairing, 0 = stereo |
| chan_sel | input | 1 | Kept channel in mono: 0 left, 1 right |
| cs_sel | input | 1 | Channel-status block select for the frame |
| out_valid | output | 1 | One-cycle frame strobe |
| out_a | output | 24 | Subframe A word |
| out_b | output | 24 | Subframe B word |
| out_tag | output | 1 | Channel-status block tag for the frame |

## Verification
A configuration change and a sample strobe can land in the same cycle. In that case the phase clear must take effect before the strobe is classified, so the strobe opens a new pair instead of closing the old one. The bench provokes this in two ways: it flips `chan_sel` in the cycle of the second strobe of a pair, and it drops `mono_en` together with a strobe. A scoreboard, fed by an independent model of the pairing, then judges the result. Any frame built from the stale held sample shows up either as an unexpected frame or as an A word mismatch.

// File: rtl/spp_pkg.sv
package spp_pkg;

    localparam int unsigned DEF_SAMPLE_W = 24;

    typedef enum logic {
        PH_EMPTY = 1'b0,
        PH_HALF  = 1'b1
    } pair_ph_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        logic  mono;
        chan_e chan;
    } pack_cfg_t;

endpackage

// File: rtl/spp_cfg_watch.sv
module spp_cfg_watch
    import spp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mono_en,
    input  logic chan_sel,
    output logic cfg_change
);

    pack_cfg_t cfg_d, cfg_q;
    pack_cfg_t cfg_now;

    always_comb begin
        cfg_now.mono = mono_en;
        cfg_now.chan = chan_e'(chan_sel);
        cfg_d        = cfg_now;
        cfg_change   = (cfg_now.mono != cfg_q.mono) ||
                       (cfg_now.chan != cfg_q.chan);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mono <= 1'b0;
            cfg_q.chan <= CH_LEFT;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/spp_chan_pick.sv
module spp_chan_pick
    import spp_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic [SAMPLE_W-1:0] left_w,
    input  logic [SAMPLE_W-1:0] right_w,
    input  logic                chan_sel,
    output logic [SAMPLE_W-1:0] picked_w
);

    chan_e sel_chan;

    always_comb begin
        sel_chan = chan_e'(chan_sel);
        unique case (sel_chan)
            CH_RIGHT: picked_w = right_w;
            default:  picked_w = left_w;
        endcase
    end

endmodule

// File: rtl/spp_pair_core.sv
module spp_pair_core
    import spp_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                mono_en,
    input  logic                cfg_change,
    input  logic                cs_sel,
    input  logic [SAMPLE_W-1:0] left_w,
    input  logic [SAMPLE_W-1:0] right_w,
    input  logic [SAMPLE_W-1:0] picked_w,
    output logic                frm_valid,
    output logic [SAMPLE_W-1:0] frm_a,
    output logic [SAMPLE_W-1:0] frm_b,
    output logic                frm_tag
);

    typedef struct packed {
        pair_ph_e            phase;
        logic [SAMPLE_W-1:0] hold;
        logic                ov;
        logic [SAMPLE_W-1:0] a;
        logic [SAMPLE_W-1:0] b;
        logic                tag;
    } core_st_t;

    core_st_t st_d, st_q;
    pair_ph_e eff_phase;

    always_comb begin
        st_d      = st_q;
        st_d.ov   = 1'b0;
        // a configuration change restarts pairing before the strobe is classified
        eff_phase = cfg_change ? PH_EMPTY : st_q.phase;
        st_d.phase = mono_en ? eff_phase : PH_EMPTY;

        if (in_valid) begin
            if (!mono_en) begin
                st_d.ov  = 1'b1;
                st_d.a   = left_w;
                st_d.b   = right_w;
                st_d.tag = cs_sel;
            end else if (eff_phase == PH_EMPTY) begin
                st_d.hold  = picked_w;
                st_d.phase = PH_HALF;
            end else begin
                st_d.ov    = 1'b1;
                st_d.a     = st_q.hold;
                st_d.b     = picked_w;
                st_d.tag   = cs_sel;
                st_d.phase = PH_EMPTY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_EMPTY;
            st_q.hold  <= '0;
            st_q.ov    <= 1'b0;
            st_q.a     <= '0;
            st_q.b     <= '0;
            st_q.tag   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frm_valid = st_q.ov;
    assign frm_a     = st_q.a;
    assign frm_b     = st_q.b;
    assign frm_tag   = st_q.tag;

endmodule

// File: rtl/subframe_pair_packer.sv
module subframe_pair_packer
    import spp_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                mono_en,
    input  logic                chan_sel,
    input  logic                cs_sel,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_a,
    output logic [SAMPLE_W-1:0] out_b,
    output logic                out_tag
);

    logic                cfg_change;
    logic [SAMPLE_W-1:0] picked_w;

    spp_cfg_watch u_cfg (
        .clk        (clk),
        .rst        (rst),
        .mono_en    (mono_en),
        .chan_sel   (chan_sel),
        .cfg_change (cfg_change)
    );

    spp_chan_pick #(.SAMPLE_W(SAMPLE_W)) u_pick (
        .left_w   (in_left),
        .right_w  (in_right),
        .chan_sel (chan_sel),
        .picked_w (picked_w)
    );

    spp_pair_core #(.SAMPLE_W(SAMPLE_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .mono_en    (mono_en),
        .cfg_change (cfg_change),
        .cs_sel     (cs_sel),
        .left_w     (in_left),
        .right_w    (in_right),
        .picked_w   (picked_w),
        .frm_valid  (out_valid),
        .frm_a      (out_a),
        .frm_b      (out_b),
        .frm_tag    (out_tag)
    );

endmodule

// File: rtl/spp_packer_checks.sv
module spp_packer_checks #(
    parameter int unsigned SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_left,
    input logic [SAMPLE_W-1:0] in_right,
    input logic                mono_en,
    input logic                chan_sel,
    input logic                cs_sel,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_a,
    input logic [SAMPLE_W-1:0] out_b,
    input logic                out_tag
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !out_valid);

    a_r2_stereo_map: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mono_en) |=>
            (out_valid && out_a == $past(in_left) && out_b == $past(in_right)));

    a_r3_mono_b_word: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mono_en)) |->
            (out_b == ($past(chan_sel) ? $past(in_right) : $past(in_left))));

    a_r5_half_rate: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mono_en && $past(mono_en)) |=> !out_valid);

    a_r6_tag_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_tag == $past(cs_sel)));

    a_r8_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

endmodule

bind subframe_pair_packer spp_packer_checks #(.SAMPLE_W(SAMPLE_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .mono_en   (mono_en),
    .chan_sel  (chan_sel),
    .cs_sel    (cs_sel),
    .out_valid (out_valid),
    .out_a     (out_a),
    .out_b     (out_b),
    .out_tag   (out_tag)
);

// File: tb/subframe_pair_packer_bench.sv
module subframe_pair_packer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_left = '0;
    logic [W-1:0] in_right = '0;
    logic         mono_en = 1'b0;
    logic         chan_sel = 1'b0;
    logic         cs_sel = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_a;
    logic [W-1:0] out_b;
    logic         out_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    subframe_pair_packer #(.SAMPLE_W(W)) u_subframe_pair_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .mono_en(mono_en), .chan_sel(chan_sel),
        .cs_sel(cs_sel), .out_valid(out_valid), .out_a(out_a),
        .out_b(out_b), .out_tag(out_tag)
    );

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         tag;
        logic         mono;
        string        req;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad = 0;

    // independent model of the pairing
    logic         m_mode = 1'b0;
    logic         m_chan = 1'b0;
    logic         m_half = 1'b0;
    logic [W-1:0] m_hold = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic model_cfg(input logic mono, input logic chan);
        if (mono != m_mode || chan != m_chan) m_half = 1'b0;
        if (!mono) m_half = 1'b0;
        m_mode = mono;
        m_chan = chan;
    endtask

    // one strobe cycle, driven at the falling edge
    task automatic strobe(input logic [W-1:0] l, input logic [W-1:0] r,
                          input logic mono, input logic chan, input logic cs,
                          input string req);
        exp_t e;
        logic [W-1:0] pk;
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        mono_en = mono; chan_sel = chan; cs_sel = cs;
        model_cfg(mono, chan);
        pk = chan ? r : l;
        if (!mono) begin
            e.a = l; e.b = r; e.tag = cs; e.mono = 1'b0; e.req = req;
            exp_q.push_back(e);
        end else if (!m_half) begin
            m_hold = pk; m_half = 1'b1;
        end else begin
            e.a = m_hold; e.b = pk; e.tag = cs; e.mono = 1'b1; e.req = req;
            exp_q.push_back(e);
            m_half = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            model_cfg(mono_en, chan_sel);
        end
    endtask

    // monitor: compare each produced frame with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R8", "unexpected frame a", out_a, '0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_a == e.a, e.req, "subframe A", out_a, e.a);
                    check(out_b == e.b, e.req, "subframe B", out_b, e.b);
                    check(out_tag == e.tag, "R6", "tag", W'(out_tag), W'(e.tag));
                    if (e.mono)
                        check(out_a[W-1:W-8] != 8'hEE && out_b[W-1:W-8] != 8'hEE,
                              "R4", "discarded channel leaked", out_a, e.a);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        check(1'b0, "WATCHDOG", "timeout", '0, '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", W'(out_valid), '0);
        @(negedge clk); rst = 1'b0;
        idle(2);
        check(out_valid == 1'b0, "R1", "out_valid after reset", W'(out_valid), '0);

        // R2 stereo mapping, varied patterns, tag R6
        strobe(24'h111111, 24'h222222, 0, 0, 0, "R2");
        strobe(24'hABCDEF, 24'h012345, 0, 1, 1, "R2");
        idle(1);
        strobe(24'hFFFFFF, 24'h000000, 0, 0, 1, "R2");
        idle(3);

        // R3 mono left, right words marked as discard (R4)
        strobe(24'h100001, 24'hEE0001, 1, 0, 0, "R3");
        idle(2);
        check(out_valid == 1'b0, "R5", "no frame after opening strobe", W'(out_valid), '0);
        strobe(24'h100002, 24'hEE0002, 1, 0, 1, "R3");
        strobe(24'h100003, 24'hEE0003, 1, 0, 0, "R3");
        strobe(24'h100004, 24'hEE0004, 1, 0, 1, "R3");
        idle(3);

        // R3 mono right, back-to-back strobes (R5)
        strobe(24'hEE0005, 24'h200005, 1, 1, 0, "R3");
        strobe(24'hEE0006, 24'h200006, 1, 1, 1, "R3");
        strobe(24'hEE0007, 24'h200007, 1, 1, 0, "R5");
        strobe(24'hEE0008, 24'h200008, 1, 1, 0, "R5");
        idle(3);

        // R7 channel flip in the same cycle as the pair-closing strobe
        strobe(24'h300009, 24'hEE0009, 1, 0, 0, "R7");
        strobe(24'hEE000A, 24'h30000A, 1, 1, 0, "R7");
        strobe(24'hEE000B, 24'h30000B, 1, 1, 1, "R7");
        idle(3);

        // R7 mode drop together with a strobe after a half pair
        strobe(24'h40000C, 24'hEE000C, 1, 0, 0, "R7");
        strobe(24'h50000D, 24'h60000D, 0, 0, 1, "R7");
        idle(1);
        strobe(24'h40000E, 24'hEE000E, 1, 0, 0, "R7");
        strobe(24'h40000F, 24'hEE000F, 1, 0, 0, "R7");
        idle(3);

        // R1 reset in mid pair
        strobe(24'h700010, 24'hEE0010, 1, 0, 0, "R1");
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_mode = 1'b0; m_chan = 1'b0; m_half = 1'b0;
        idle(1);
        strobe(24'h700011, 24'hEE0011, 1, 0, 1, "R1");
        strobe(24'h700012, 24'hEE0012, 1, 0, 0, "R1");
        idle(4);

        check(exp_q.size() == 0, "R8", "frames missing", W'(exp_q.size()), '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule